// File: doc/BRIEF.md
# Half to Single Precision Widener

This unit takes a 16-bit half-precision floating-point code and returns the 32-bit single-precision code for the same value. The conversion is exact, so no rounding or flags beyond invalid are needed. A strobe launches each conversion. The result, a matching valid and an invalid-operation flag appear on registered outputs on the next clock edge. The unit accepts one operand per cycle with no stall.

A mode input picks how the top exponent code (all ones) is read. In standard mode it encodes infinity or NaN. In the extended-range mode it is an ordinary finite exponent, so the format has no special values. Tiny half inputs (zero exponent, nonzero fraction) are normalized with a leading-zero count. Single precision has enough exponent range to hold every such value as a normal number.

Top module: `half_to_single_widen`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and the outputs carry that operand's result. When `in_valid` is low at an edge, `out_valid` is low after it and `single_out` and `invalid_flag` keep their previous values.
- R2: Bit 31 of the result always equals bit 15 of the input (the sign).
- R3: An input whose bits 14:0 are all zero gives a result whose bits 30:0 are all zero (a signed zero).
- R4: For a half exponent field (bits 14:10) in the range 1..30, the single exponent field (bits 30:23) is the half exponent plus 112. The single fraction (bits 22:0) is the half fraction (bits 9:0) followed by 13 zero bits.
- R5: For a zero half exponent with nonzero fraction f, the fraction is shifted left until its leading one moves past bit 9. The single exponent is 113 minus the number of shifts. The shifted 10 low bits, followed by 13 zeros, form the single fraction.
- R6: In standard mode (`alt_mode` = 0), exponent 31 with a zero fraction gives infinity: exponent field 255, fraction 0, sign kept.
- R7: In standard mode, exponent 31 with a nonzero fraction gives a NaN with exponent field 255. The fraction is the half fraction with bit 9 forced to 1, followed by 13 zeros.
- R8: `invalid_flag` is 1 exactly when the converted operand was taken in standard mode, had exponent 31, a nonzero fraction, and fraction bit 9 clear (a signalling NaN). It is 0 for every other operand.
- R9: In extended mode (`alt_mode` = 1), exponent 31 is finite: the single exponent is 143, the fraction is widened as in R4, and `invalid_flag` is 0.
- R10: While `rst_n` is low, `out_valid`, `single_out` and `invalid_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: convert `half_in` at this edge |
| alt_mode | input | 1 | 1 = extended-range half format without special values |
| half_in | input | 16 | Half-precision operand |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| single_out | output | 32 | Single-precision result |
| invalid_flag | output | 1 | Signalling NaN seen in standard mode |

## Verification
The bench sweeps every one of the 65536 half codes in both modes. It compares each result against a value built with arithmetic, so all tiny inputs are covered, from fraction 1 to fraction 0x3FF. A wrong leading-zero count would give an exponent off by a power of two. Dropping the hidden-bit shift would leave a stray leading one in the fraction. The top exponent code is checked in both modes. A design that ignored the mode would turn large finite values into NaNs or infinities, or raise invalid for them. A design that failed to set the quiet bit, or flagged quiet NaNs, would show a wrong fraction bit 22 or a wrong flag. The hold check after the strobe drops makes sure that idle cycles leave the outputs unchanged.

// File: rtl/half_to_single_widen.sv
module half_to_single_widen #(
  parameter int HALF_EXP_W = 5,
  parameter int HALF_FRAC_W = 10,
  parameter int SGL_EXP_W = 8,
  parameter int SGL_FRAC_W = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        alt_mode,
  input  logic [15:0] half_in,
  output logic        out_valid,
  output logic [31:0] single_out,
  output logic        invalid_flag
);

  localparam int HALF_W = 1 + HALF_EXP_W + HALF_FRAC_W;
  localparam int SGL_W = 1 + SGL_EXP_W + SGL_FRAC_W;
  localparam int HALF_BIAS = (1 << (HALF_EXP_W - 1)) - 1;
  localparam int SGL_BIAS = (1 << (SGL_EXP_W - 1)) - 1;
  localparam int REBIAS = SGL_BIAS - HALF_BIAS;
  localparam int PAD_W = SGL_FRAC_W - HALF_FRAC_W;
  localparam int LZ_W = $clog2(HALF_FRAC_W);

  function automatic logic [LZ_W-1:0] lead_zeros(input logic [HALF_FRAC_W-1:0] f);
    logic [LZ_W-1:0] n;
    logic seen;
    n = '0;
    seen = 1'b0;
    for (int i = HALF_FRAC_W - 1; i >= 0; i--) begin
      if (!seen && f[i]) seen = 1'b1;
      else if (!seen) n = n + 1'b1;
    end
    return n;
  endfunction

  logic                   sgn;
  logic [HALF_EXP_W-1:0]  hexp;
  logic [HALF_FRAC_W-1:0] hfrac;
  logic                   exp_top, exp_zero, frac_nz, special, snan;
  logic [LZ_W-1:0]        lz;
  logic [HALF_FRAC_W-1:0] lifted, sub_frac;
  logic [SGL_EXP_W-1:0]   wexp;
  logic [HALF_FRAC_W-1:0] wfrac;
  logic [SGL_W-1:0]       wide;

  assign sgn      = half_in[HALF_W-1];
  assign hexp     = half_in[HALF_W-2 -: HALF_EXP_W];
  assign hfrac    = half_in[HALF_FRAC_W-1:0];
  assign exp_top  = &hexp;
  assign exp_zero = ~|hexp;
  assign frac_nz  = |hfrac;
  assign special  = exp_top & ~alt_mode;
  assign snan     = special & frac_nz & ~hfrac[HALF_FRAC_W-1];

  assign lz       = lead_zeros(hfrac);
  assign lifted   = hfrac << lz;
  assign sub_frac = {lifted[HALF_FRAC_W-2:0], 1'b0};

  always_comb begin
    if (special) begin
      wexp  = '1;
      wfrac = hfrac | (frac_nz ? {1'b1, {(HALF_FRAC_W-1){1'b0}}} : '0);
    end else if (exp_zero && !frac_nz) begin
      wexp  = '0;
      wfrac = '0;
    end else if (exp_zero) begin
      wexp  = SGL_EXP_W'(REBIAS) - SGL_EXP_W'(lz);
      wfrac = sub_frac;
    end else begin
      wexp  = SGL_EXP_W'(hexp) + SGL_EXP_W'(REBIAS);
      wfrac = hfrac;
    end
  end

  assign wide = {sgn, wexp, wfrac, {PAD_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      single_out   <= '0;
      invalid_flag <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        single_out   <= wide;
        invalid_flag <= snan;
      end
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(single_out) && $stable(invalid_flag)));

  assert_sign_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> single_out[31] == $past(half_in[15]));

  assert_zero_signed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && half_in[14:0] == 15'd0) |=> single_out[30:0] == 31'd0);

  assert_flag_means_quiet_nan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_flag |-> (single_out[30:23] == 8'hFF && single_out[22]));

  assert_alt_finite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && alt_mode) |=> (!invalid_flag && single_out[30:23] != 8'hFF));

endmodule

// File: tb/half_to_single_widen_tb.sv
module half_to_single_widen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic alt_mode = 1'b0;
  logic [15:0] half_in = '0;
  logic out_valid;
  logic [31:0] single_out;
  logic invalid_flag;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  half_to_single_widen dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .alt_mode(alt_mode),
    .half_in(half_in), .out_valid(out_valid), .single_out(single_out),
    .invalid_flag(invalid_flag)
  );

  function automatic logic [31:0] ref_value(input logic [15:0] h, input logic alt);
    int e;
    int m;
    int f;
    logic [31:0] r;
    e = (h >> 10) & 31;
    f = h & 1023;
    r = {h[15], 31'd0};
    if (e == 31 && !alt) begin
      if (f != 0) f = f | 512;
      r[30:23] = 8'd255;
      r[22:0] = 23'(f * 8192);
    end else if (e == 0 && f == 0) begin
      r[30:0] = '0;
    end else if (e == 0) begin
      m = f;
      e = 113;
      while (m < 1024) begin
        m = m * 2;
        e = e - 1;
      end
      r[30:23] = 8'(e);
      r[22:0] = 23'((m - 1024) * 8192);
    end else begin
      r[30:23] = 8'(e + 112);
      r[22:0] = 23'(f * 8192);
    end
    return r;
  endfunction

  function automatic logic ref_flag(input logic [15:0] h, input logic alt);
    return !alt && h[14:10] == 5'h1F && h[9:0] != 0 && !h[9];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_result(input logic [15:0] h, input logic alt);
    string tag;
    if (h[14:10] == 5'h1F && alt) tag = "R9 extended top exponent";
    else if (h[14:10] == 5'h1F && h[9:0] == 0) tag = "R6 infinity";
    else if (h[14:10] == 5'h1F) tag = "R7 NaN quieting";
    else if (h[14:0] == 0) tag = "R3 signed zero";
    else if (h[14:10] == 0) tag = "R5 tiny normalize";
    else tag = "R4 normal rebias";
    check("R1 out_valid", 64'(out_valid), 64'd1);
    check(tag, 64'(single_out), 64'(ref_value(h, alt)));
    check("R2 sign", 64'(single_out[31]), 64'(h[15]));
    check("R8 invalid flag", 64'(invalid_flag), 64'(ref_flag(h, alt)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog R1: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] prev_h;
    logic prev_alt;
    logic [31:0] held;
    bit have_prev;
    have_prev = 1'b0;
    prev_h = '0;
    prev_alt = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset valid", 64'(out_valid), 64'd0);
    check("R10 reset result", 64'(single_out), 64'd0);
    check("R10 reset flag", 64'(invalid_flag), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int md = 0; md < 2; md++) begin
      for (int c = 0; c < 65536; c++) begin
        in_valid = 1'b1;
        alt_mode = md[0];
        half_in = 16'(c);
        @(negedge clk);
        check_result(16'(c), md[0]);
        have_prev = 1'b1;
        prev_h = 16'(c);
        prev_alt = md[0];
      end
    end
    in_valid = 1'b0;
    half_in = 16'hFC01;
    alt_mode = 1'b0;
    held = single_out;
    @(negedge clk);
    check("R1 idle valid low", 64'(out_valid), 64'd0);
    check("R1 idle result held", 64'(single_out), 64'(held));
    if (have_prev)
      check("R1 idle flag held", 64'(invalid_flag), 64'(ref_flag(prev_h, prev_alt)));
    @(negedge clk);
    check("R1 idle result still held", 64'(single_out), 64'(held));
    in_valid = 1'b1;
    half_in = 16'h7D00;
    @(negedge clk);
    check("R8 signalling NaN flag", 64'(invalid_flag), 64'd1);
    check("R7 quieted NaN", 64'(single_out), 64'h7FE00000);
    half_in = 16'hFC00;
    alt_mode = 1'b1;
    @(negedge clk);
    check("R9 extended max", 64'(single_out), 64'hC7800000);
    check("R9 no flag", 64'(invalid_flag), 64'd0);
    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule